// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the SDRAM command bus from reset until the memory is usable, and then keeps it refreshed. After reset it waits out the power-up delay. It then closes every bank and runs a configurable number of auto-refresh cycles. Finally it programs the mode register with the CAS latency and raises `init_done`. From that point on, an interval timer asks for a refresh at a fixed period. The access engine that shares the bus grants each refresh with an acknowledge. The block then issues PRECHARGE ALL and AUTO REFRESH and keeps the request high until the refresh has completed.

All timings are parameters given in picoseconds, together with the clock period. The block turns them into whole clock-cycle counts at elaboration. The refresh interval is rounded down, so the memory is never refreshed too rarely. Every other delay is rounded up, so no minimum is violated. Refresh intervals that expire while the access engine is still holding the bus are counted, up to a limit, and each one is served by a separate grant.

Top module: `sdram_init_refresh_seq`

## Requirements
- R1: While `rst_n` is low, the command pins show NOP, `addr` is zero, and both `init_done` and `refresh_req` are low.
- R2: The first command after reset release is PRECHARGE ALL (`addr[10]`=1). It appears on the PWR_CYC-th rising edge after release, and every cycle before it is NOP.
- R3: After that precharge, INIT_REFS AUTO REFRESH commands follow. The first comes TRP_CYC cycles after the precharge, and each later one comes TRFC_CYC cycles after the one before it.
- R4: LOAD MODE REGISTER follows TRFC_CYC cycles after the last initialization refresh. Its `addr[6:4]` carries the CAS latency and all other address bits are 0. `init_done` rises in the same cycle and never falls again.
- R5: PWR_CYC, TRP_CYC and TRFC_CYC are the smallest cycle counts whose duration is at least the target. REF_CYC is the largest cycle count whose duration does not exceed the refresh target. Each count is at least 1.
- R6: Only four pin codes appear on {cs_n,ras_n,cas_n,we_n}: NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001 and LOAD MODE=0000. During NOP, `addr` is zero.
- R7: `refresh_req` rises REF_CYC cycles after LOAD MODE REGISTER. Further intervals expire every REF_CYC cycles after that, whatever the state of the handshake.
- R8: While a refresh is pending and not acknowledged, only NOP is driven. When `refresh_ack` is sampled high while `refresh_req` is high, PRECHARGE ALL appears in the next cycle, and AUTO REFRESH follows TRP_CYC cycles later.
- R9: If no other interval is pending, `refresh_req` falls TRFC_CYC cycles after that AUTO REFRESH.
- R10: Intervals that expire while a refresh is pending are counted, up to PEND_MAX. `refresh_req` stays high until each counted interval has been served by its own acknowledge.
- R11: `refresh_ack` while `refresh_req` is low has no effect: the next cycle is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_ack | input | 1 | Access engine yields the bus for a pending refresh |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode word for LOAD MODE |
| init_done | output | 1 | Initialization finished, bus may be used |
| refresh_req | output | 1 | One or more refreshes pending |

## Verification
The bench measures the gap between successive commands. With the default 20 ns clock, tRFC of 70 ns must become 4 cycles and the refresh period must become 781 cycles. A design that truncated tRFC would issue the next command one cycle early, and one that rounded the interval up would drift later on every refresh. The bench also holds off the acknowledge across a whole interval: a design that kept only a single pending flag would drop `refresh_req` after one refresh instead of asking again. Acknowledges are given at random delays, plus one stray acknowledge before any request. An off-by-one in the handshake path would show up as a command in the wrong cycle or as a spurious precharge.

// File: rtl/sdr_seq_pkg.sv
`timescale 1ns/1ps
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_POWERUP,
    ST_INIT_REF,
    ST_LOAD_MODE,
    ST_RUN,
    ST_RF_AREF,
    ST_RF_HOLD
  } seq_state_e;

  localparam int PRE_ALL_BIT = 10;

  // Smallest cycle count covering at least t_ps (never below one).
  function automatic int cycles_at_least(longint t_ps, longint clk_ps);
    longint n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return int'(n);
  endfunction

  // Largest cycle count not exceeding t_ps (never below one).
  function automatic int cycles_at_most(longint t_ps, longint clk_ps);
    longint n;
    n = t_ps / clk_ps;
    if (n < 1) n = 1;
    return int'(n);
  endfunction

  // Mode word: burst length 1, sequential, CAS latency in bits 6:4.
  function automatic logic [15:0] mode_word(int cas_lat);
    logic [15:0] w;
    w = '0;
    w[6:4] = 3'(cas_lat);
    return w;
  endfunction

endpackage

// File: rtl/sdr_delay_counter.sv
`timescale 1ns/1ps
module sdr_delay_counter #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdr_refresh_timer.sv
`timescale 1ns/1ps
module sdr_refresh_timer #(
  parameter int REF_CYC  = 781,
  parameter int PEND_MAX = 3,
  parameter int PW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          served,
  output logic          tick,
  output logic [PW-1:0] pending
);
  localparam int TW = $clog2(REF_CYC + 1);
  localparam logic [TW-1:0] RELOAD = TW'(REF_CYC - 1);
  localparam logic [PW-1:0] PMAX = PW'(PEND_MAX);

  logic [TW-1:0] cnt;
  logic inc, dec;

  assign tick = run && (cnt == '0);
  assign dec  = served && (pending != '0);
  assign inc  = tick && ((pending != PMAX) || dec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RELOAD;
    end else if (run) begin
      cnt <= (cnt == '0) ? RELOAD : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end
endmodule

// File: rtl/sdr_cmd_fsm.sv
`timescale 1ns/1ps
module sdr_cmd_fsm
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DW        = 13,
  parameter int PWR_CYC   = 5000,
  parameter int TRP_CYC   = 1,
  parameter int TRFC_CYC  = 4,
  parameter int INIT_REFS = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_req,
  input  logic              refresh_ack,
  output sdr_cmd_e          cmd,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              served
);
  localparam int RW = $clog2(INIT_REFS + 1);
  localparam logic [DW-1:0] TRP_LD  = DW'(TRP_CYC - 1);
  localparam logic [DW-1:0] TRFC_LD = DW'(TRFC_CYC - 1);
  localparam logic [RW-1:0] REFS_LD = RW'(INIT_REFS);

  seq_state_e        state, state_d;
  logic [RW-1:0]     refs_left, refs_left_d;
  sdr_cmd_e          cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic              ld, zero, done_set;
  logic [DW-1:0]     ld_val;
  logic [ADDR_W-1:0] pre_all;

  always_comb begin
    pre_all = '0;
    pre_all[PRE_ALL_BIT] = 1'b1;
  end

  sdr_delay_counter #(
    .W       (DW),
    .RST_VAL (DW'(PWR_CYC - 1))
  ) i_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_val (ld_val),
    .zero     (zero)
  );

  always_comb begin
    state_d     = state;
    refs_left_d = refs_left;
    cmd_d       = CMD_NOP;
    addr_d      = '0;
    ld          = 1'b0;
    ld_val      = '0;
    done_set    = 1'b0;
    served      = 1'b0;
    unique case (state)
      ST_POWERUP: if (zero) begin
        cmd_d       = CMD_PRE;
        addr_d      = pre_all;
        ld          = 1'b1;
        ld_val      = TRP_LD;
        refs_left_d = REFS_LD;
        state_d     = ST_INIT_REF;
      end
      ST_INIT_REF: if (zero) begin
        cmd_d       = CMD_AREF;
        ld          = 1'b1;
        ld_val      = TRFC_LD;
        refs_left_d = refs_left - 1'b1;
        if (refs_left == RW'(1)) state_d = ST_LOAD_MODE;
      end
      ST_LOAD_MODE: if (zero) begin
        cmd_d    = CMD_LMR;
        addr_d   = MODE_WORD;
        done_set = 1'b1;
        state_d  = ST_RUN;
      end
      ST_RUN: if (refresh_req && refresh_ack) begin
        cmd_d   = CMD_PRE;
        addr_d  = pre_all;
        ld      = 1'b1;
        ld_val  = TRP_LD;
        state_d = ST_RF_AREF;
      end
      ST_RF_AREF: if (zero) begin
        cmd_d   = CMD_AREF;
        ld      = 1'b1;
        ld_val  = TRFC_LD;
        state_d = ST_RF_HOLD;
      end
      ST_RF_HOLD: if (zero) begin
        served  = 1'b1;
        state_d = ST_RUN;
      end
      default: state_d = ST_POWERUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_POWERUP;
      refs_left <= '0;
      cmd       <= CMD_NOP;
      addr      <= '0;
      init_done <= 1'b0;
    end else begin
      state     <= state_d;
      refs_left <= refs_left_d;
      cmd       <= cmd_d;
      addr      <= addr_d;
      if (done_set) init_done <= 1'b1;
    end
  end
endmodule

// File: rtl/sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module sdram_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int     ADDR_W       = 12,
  parameter longint T_CLK_PS     = 20000,
  parameter longint T_POWERUP_PS = 100000000,
  parameter longint T_REFRESH_PS = 15625000,
  parameter longint T_RFC_PS     = 70000,
  parameter longint T_RP_PS      = 20000,
  parameter int     INIT_REFS    = 2,
  parameter int     CAS_LAT      = 3,
  parameter int     PEND_MAX     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_ack,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              refresh_req
);
  localparam int PWR_CYC  = cycles_at_least(T_POWERUP_PS, T_CLK_PS);
  localparam int TRP_CYC  = cycles_at_least(T_RP_PS, T_CLK_PS);
  localparam int TRFC_CYC = cycles_at_least(T_RFC_PS, T_CLK_PS);
  localparam int REF_CYC  = cycles_at_most(T_REFRESH_PS, T_CLK_PS);
  localparam int DMAX     = (PWR_CYC > TRFC_CYC) ?
                            ((PWR_CYC > TRP_CYC) ? PWR_CYC : TRP_CYC) :
                            ((TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC);
  localparam int DW       = $clog2(DMAX + 1);
  localparam int PW       = $clog2(PEND_MAX + 1);
  localparam logic [15:0] MODE16 = mode_word(CAS_LAT);
  localparam logic [ADDR_W-1:0] MODE_WORD = MODE16[ADDR_W-1:0];

  // Named internal events, observed by the bound checker.
  sdr_cmd_e      cmd_w;
  logic          timer_tick;
  logic          refresh_served;
  logic [PW-1:0] pending_cnt;

  sdr_cmd_fsm #(
    .ADDR_W    (ADDR_W),
    .DW        (DW),
    .PWR_CYC   (PWR_CYC),
    .TRP_CYC   (TRP_CYC),
    .TRFC_CYC  (TRFC_CYC),
    .INIT_REFS (INIT_REFS),
    .MODE_WORD (MODE_WORD)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .refresh_req (refresh_req),
    .refresh_ack (refresh_ack),
    .cmd         (cmd_w),
    .addr        (addr),
    .init_done   (init_done),
    .served      (refresh_served)
  );

  sdr_refresh_timer #(
    .REF_CYC  (REF_CYC),
    .PEND_MAX (PEND_MAX),
    .PW       (PW)
  ) i_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (init_done),
    .served  (refresh_served),
    .tick    (timer_tick),
    .pending (pending_cnt)
  );

  assign refresh_req = (pending_cnt != '0);
  assign {cs_n, ras_n, cas_n, we_n} = cmd_w;
endmodule

// File: rtl/sdr_seq_checker.sv
`timescale 1ns/1ps
module sdr_seq_checker
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int TRFC_CYC = 4,
  parameter int PEND_MAX = 3,
  parameter int PW       = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              refresh_req,
  input logic              refresh_ack,
  input logic              timer_tick,
  input logic [PW-1:0]     pending_cnt
);
  logic [3:0] pins;
  assign pins = {cs_n, ras_n, cas_n, we_n};

  // R6
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_NOP && addr == '0) || pins == CMD_PRE ||
    pins == CMD_AREF || pins == CMD_LMR);

  // R4
  init_done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R4
  init_mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (pins == CMD_LMR && addr == MODE_WORD));

  // R8
  pre_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && pins == CMD_PRE) |-> $past(refresh_ack && refresh_req));

  // R11
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !refresh_req) |=> pins == CMD_NOP);

  // R3
  aref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == CMD_AREF && TRFC_CYC > 1) |=> pins == CMD_NOP);

  // R10
  pending_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending_cnt <= PW'(PEND_MAX));

  // R10
  tick_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_tick |=> refresh_req);
endmodule

bind sdram_init_refresh_seq sdr_seq_checker #(
  .ADDR_W    (ADDR_W),
  .TRFC_CYC  (TRFC_CYC),
  .PEND_MAX  (PEND_MAX),
  .PW        (PW),
  .MODE_WORD (MODE_WORD)
) i_sdr_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .addr        (addr),
  .init_done   (init_done),
  .refresh_req (refresh_req),
  .refresh_ack (refresh_ack),
  .timer_tick  (timer_tick),
  .pending_cnt (pending_cnt)
);

// File: tb/test_sdram_init_refresh_seq.sv
`timescale 1ns/1ps
module test_sdram_init_refresh_seq;
  localparam int     ADDR_W    = 12;
  localparam longint CLK_PS    = 20000;
  localparam longint PWR_PS    = 100000000;
  localparam longint REF_PS    = 15625000;
  localparam longint RFC_PS    = 70000;
  localparam longint RP_PS     = 20000;
  localparam int     INIT_REFS = 2;
  localparam int     CAS_LAT   = 3;

  localparam logic [3:0] P_NOP = 4'b0111, P_PRE = 4'b0010,
                         P_AREF = 4'b0001, P_LMR = 4'b0000;

  // Bench's own rounding: counted up or down in whole clock steps.
  function automatic int up_cycles(longint t, longint p);
    int n = 0;
    while (longint'(n) * p < t) n++;
    return (n < 1) ? 1 : n;
  endfunction
  function automatic int down_cycles(longint t, longint p);
    int n = 0;
    while (longint'(n + 1) * p <= t) n++;
    return (n < 1) ? 1 : n;
  endfunction

  int e_pwr, e_rp, e_rfc, e_ref;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_ack = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, init_done, refresh_req;
  logic [ADDR_W-1:0] addr;
  wire  [3:0] pins = {cs_n, ras_n, cas_n, we_n};

  always #10 clk = ~clk;

  sdram_init_refresh_seq #(
    .ADDR_W(ADDR_W), .T_CLK_PS(CLK_PS), .T_POWERUP_PS(PWR_PS),
    .T_REFRESH_PS(REF_PS), .T_RFC_PS(RFC_PS), .T_RP_PS(RP_PS),
    .INIT_REFS(INIT_REFS), .CAS_LAT(CAS_LAT), .PEND_MAX(3)
  ) i_sdram_init_refresh_seq (
    .clk(clk), .rst_n(rst_n), .refresh_ack(refresh_ack),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .init_done(init_done), .refresh_req(refresh_req)
  );

  int checks = 0, fails = 0, bad_pins = 0;
  longint smp = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic step;
    @(negedge clk);
    smp++;
  endtask

  // R6 monitor: legal codes only, zero address on NOP
  always @(negedge clk) if (rst_n) begin
    if (!(pins inside {P_NOP, P_PRE, P_AREF, P_LMR})) bad_pins++;
    if (pins == P_NOP && addr != '0) bad_pins++;
  end

  task automatic next_cmd(output int gap);
    gap = 0;
    do begin
      step();
      gap++;
    end while (pins == P_NOP && gap < 20000);
  endtask

  // Serve one pending refresh after 'delay' idle cycles.
  task automatic serve(int delay, bit more);
    int gap, n, idle_bad;
    idle_bad = 0;
    repeat (delay) begin
      step();
      if (pins != P_NOP || !refresh_req) idle_bad++;
    end
    chk(idle_bad == 0, "R8 idle while pending", idle_bad, 0);
    refresh_ack = 1'b1;
    step();
    refresh_ack = 1'b0;
    chk(pins == P_PRE && addr[10], "R8 precharge after grant", pins, P_PRE);
    next_cmd(gap);
    chk(gap == e_rp && pins == P_AREF, "R8 refresh after tRP", gap, e_rp);
    if (more) begin
      repeat (e_rfc) step();
      chk(refresh_req == 1'b1, "R10 request held for backlog", refresh_req, 1);
    end else begin
      n = 0;
      while (refresh_req && n < 100) begin step(); n++; end
      chk(n == e_rfc, "R9 request drop after tRFC", n, e_rfc);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
    end
  end

  initial begin
    int gap, t, rise;
    longint lmr_smp;
    void'($urandom(32'd1234));
    e_pwr = up_cycles(PWR_PS, CLK_PS);
    e_rp  = up_cycles(RP_PS, CLK_PS);
    e_rfc = up_cycles(RFC_PS, CLK_PS);
    e_ref = down_cycles(REF_PS, CLK_PS);

    repeat (4) step();
    chk(pins == P_NOP && addr == '0, "R1 reset command", pins, P_NOP);
    chk(init_done == 1'b0, "R1 reset init_done", init_done, 0);
    chk(refresh_req == 1'b0, "R1 reset refresh_req", refresh_req, 0);
    rst_n = 1'b1;

    // R2 / R5: power-up delay rounded up
    next_cmd(gap);
    chk(gap == e_pwr, "R2 R5 power-up cycles", gap, e_pwr);
    chk(pins == P_PRE && addr[10], "R2 first command precharge-all", pins, P_PRE);

    // R3 / R5: init refreshes with tRP then tRFC spacing
    for (int i = 0; i < INIT_REFS; i++) begin
      next_cmd(gap);
      chk(gap == ((i == 0) ? e_rp : e_rfc), "R3 R5 init refresh spacing",
          gap, (i == 0) ? e_rp : e_rfc);
      chk(pins == P_AREF, "R3 init refresh code", pins, P_AREF);
    end

    // R4
    next_cmd(gap);
    chk(gap == e_rfc && pins == P_LMR, "R4 mode load spacing", gap, e_rfc);
    chk(addr == ADDR_W'(CAS_LAT << 4), "R4 mode word", addr, CAS_LAT << 4);
    chk(init_done == 1'b1, "R4 init_done with mode load", init_done, 1);
    lmr_smp = smp;

    // R11 stray grant, then R7 first request time
    t = 0;
    while (!refresh_req && t < 2 * e_ref) begin
      refresh_ack = (t == 100);
      step();
      t++;
      if (t == 101)
        chk(pins == P_NOP, "R11 grant without request ignored", pins, P_NOP);
    end
    refresh_ack = 1'b0;
    chk(smp == lmr_smp + e_ref, "R7 R5 first request", smp - lmr_smp, e_ref);

    // Random grant delays
    rise = 1;
    for (int r = 0; r < 4; r++) begin
      if (r > 0) begin
        t = 0;
        while (!refresh_req && t < 2 * e_ref) begin step(); t++; end
        rise++;
        chk(smp == lmr_smp + longint'(rise) * e_ref, "R7 request period",
            smp - lmr_smp, longint'(rise) * e_ref);
      end
      serve(int'($urandom_range(0, 15)), 1'b0);
    end

    // R10: let a second interval expire before granting
    t = 0;
    while (!refresh_req && t < 2 * e_ref) begin step(); t++; end
    rise++;
    chk(smp == lmr_smp + longint'(rise) * e_ref, "R7 request period",
        smp - lmr_smp, longint'(rise) * e_ref);
    serve(e_ref + 5, 1'b1);
    serve(3, 1'b0);

    chk(bad_pins == 0, "R6 pin codes and NOP address", bad_pins, 0);
    finished = 1;
    summary();
  end
endmodule